// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block is a four-wire SPI slave that lets an external host reach a bank of 16-bit registers. Each register is split into two bytes, and each byte has its own 6-bit address. The lower byte sits at the even address and the upper byte at the odd address that follows. Every transfer is one 16-clock, full-duplex frame.

The first two bits of a frame select the command. `10` is a write: it carries a 6-bit address and one data byte, and it changes only the byte that the address names. `00` is a read: it carries a 6-bit address, and the full 16-bit word of that register is shifted out during the next frame. Because the link is full duplex, a host that polls continuously sends each new read while it receives the result of the previous one.

The SPI pins are synchronized into the system clock domain, and SCLK edges are detected there. The register bank itself sits outside the block. The block gives the bank a one-cycle write strobe with a word index, a byte select and a data byte, and it reads the bank through a word index and a combinational data return.

Top module: `spi_regport`

## Requirements
- R1: The output enable `dout_en` is 0 whenever `cs_n` is 1, and 1 whenever `cs_n` is 0.
- R2: While `cs_n` is 1, toggling `sclk` or `din` produces no write strobe and does not disturb a read result that is waiting for the next frame.
- R3: A completed frame whose first two bits are `10` gives one single-cycle `rb_wr_en` pulse. Address bits [5:1] select the word, address bit 0 selects the byte (0 = bits [7:0], 1 = bits [15:8]), and the last 8 frame bits are the byte. The other byte of the word is unchanged.
- R4: A completed frame whose first two bits are `00` makes the next frame return the full 16-bit word at address bits [5:1]. The odd address and the even address of a word return the same value.
- R5: Frames are most-significant bit first. `din` is sampled on rising `sclk` edges, and `dout` changes on falling `sclk` edges (clock idles high).
- R6: During back-to-back read frames, each frame returns the word named by the frame just before it.
- R7: `dout` is all zeros during the first frame after reset, and during the frame after a write frame, an aborted frame, or a frame whose first two bits are `01` or `11`.
- R8: If `cs_n` rises before 16 `sclk` rising edges have arrived, the frame is discarded and no register changes.
- R9: A frame whose first two bits are `01` or `11` writes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCLK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle high |
| cs_n | input | 1 | SPI chip select, active low |
| din | input | 1 | SPI data from the host |
| dout | output | 1 | SPI data to the host |
| dout_en | output | 1 | Tri-state enable for the `dout` pad |
| rb_wr_en | output | 1 | Single-cycle register write strobe |
| rb_wr_word | output | 5 | Word index of the write |
| rb_wr_upper | output | 1 | Byte select of the write: 1 = upper byte |
| rb_wr_data | output | 8 | Byte to write |
| rb_rd_word | output | 5 | Word index of the read |
| rb_rd_data | input | 16 | Word returned by the bank for `rb_rd_word` |

## Verification
The assertions assume the following about the inputs:
- `sclk` moves only while `cs_n` is low.
- Each `sclk` level lasts several system clocks, so every edge reaches the edge detector as a separate event.
- Writes happen only on a detected rising edge and only while chip select is active.

The stimulus respects this. Each SCLK half period is eight system clocks, and `cs_n` has a setup gap and a hold gap around every frame. The only `sclk` and `din` activity outside a frame is the deliberate idle wiggle, and it is made with `cs_n` high.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                din,
  output logic                dout,
  output logic                dout_en,
  output logic                rb_wr_en,
  output logic [ADDR_W-2:0]   rb_wr_word,
  output logic                rb_wr_upper,
  output logic [DATA_W/2-1:0] rb_wr_data,
  output logic [ADDR_W-2:0]   rb_rd_word,
  input  logic [DATA_W-1:0]   rb_rd_data
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int HDR_N  = 2 + ADDR_W;
  localparam int RX_W   = BYTE_W - 1;

  logic [2:0]        sclk_sync, cs_sync;
  logic [1:0]        din_sync;
  logic [CNT_W-1:0]  bit_cnt;
  logic [RX_W-1:0]   rx_sh;
  logic [DATA_W-1:0] tx_sh, next_tx;
  logic [1:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              dout_bit, done;

  wire din_q     = din_sync[1];
  wire cs_act    = ~cs_sync[1];
  wire cs_act_d  = ~cs_sync[2];
  wire sclk_rise = cs_act & sclk_sync[1] & ~sclk_sync[2];
  wire sclk_fall = cs_act & ~sclk_sync[1] & sclk_sync[2];
  wire in_frame  = bit_cnt < CNT_W'(DATA_W);

  assign dout        = dout_bit;
  assign dout_en     = ~cs_n;
  assign rb_wr_word  = addr_q[ADDR_W-1:1];
  assign rb_wr_upper = addr_q[0];
  assign rb_rd_word  = addr_q[ADDR_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '1;
      cs_sync   <= '1;
      din_sync  <= '0;
    end else begin
      sclk_sync <= {sclk_sync[1:0], sclk};
      cs_sync   <= {cs_sync[1:0], cs_n};
      din_sync  <= {din_sync[0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      next_tx    <= '0;
      cmd_q      <= '0;
      addr_q     <= '0;
      dout_bit   <= 1'b0;
      done       <= 1'b0;
      rb_wr_en   <= 1'b0;
      rb_wr_data <= '0;
    end else begin
      rb_wr_en <= 1'b0;
      if (cs_act && !cs_act_d) begin
        bit_cnt  <= '0;
        tx_sh    <= next_tx;
        dout_bit <= 1'b0;
        done     <= 1'b0;
      end else if (!cs_act && cs_act_d) begin
        if (!done) next_tx <= '0;
      end else if (cs_act && in_frame) begin
        if (sclk_fall) begin
          dout_bit <= tx_sh[DATA_W-1];
          tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
        end
        if (sclk_rise) begin
          rx_sh   <= {rx_sh[RX_W-2:0], din_q};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(HDR_N - 1)) begin
            cmd_q  <= rx_sh[RX_W-1 -: 2];
            addr_q <= {rx_sh[ADDR_W-2:0], din_q};
          end
          if (bit_cnt == CNT_W'(DATA_W - 1)) begin
            done <= 1'b1;
            if (cmd_q == 2'b10) begin
              rb_wr_en   <= 1'b1;
              rb_wr_data <= {rx_sh, din_q};
              next_tx    <= '0;
            end else if (cmd_q == 2'b00) begin
              next_tx <= rb_rd_data;
            end else begin
              next_tx <= '0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic rb_wr_en,
  input logic cs_act,
  input logic cs_act_d,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic dout_bit
);
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_wr_en |=> !rb_wr_en); // R3
  AST_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_wr_en |-> $past(sclk_rise)); // R3
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_wr_en |-> $past(cs_act)); // R2
  AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && cs_act_d && !sclk_fall) |=> $stable(dout_bit)); // R5
endmodule

bind spi_regport spi_regport_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rb_wr_en(rb_wr_en), .cs_act(cs_act),
  .cs_act_d(cs_act_d), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .dout_bit(dout_bit)
);

// File: tb/spi_regport_tb_top.sv
`timescale 1ns/1ps
module spi_regport_tb_top;
  localparam int HALF = 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic dout, dout_en, rb_wr_en, rb_wr_upper;
  logic [4:0]  rb_wr_word, rb_rd_word;
  logic [7:0]  rb_wr_data;
  logic [15:0] rb_rd_data;

  logic [15:0] bank [32];
  logic [15:0] mdl  [32];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] got_q [$];
  int checks = 0, failures = 0, wr_seen = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_regport dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_en(dout_en), .rb_wr_en(rb_wr_en),
    .rb_wr_word(rb_wr_word), .rb_wr_upper(rb_wr_upper),
    .rb_wr_data(rb_wr_data), .rb_rd_word(rb_rd_word), .rb_rd_data(rb_rd_data)
  );

  assign rb_rd_data = bank[rb_rd_word];

  always @(posedge clk) begin
    if (rb_wr_en) begin
      wr_seen <= wr_seen + 1;
      if (rb_wr_upper) bank[rb_wr_word][15:8] <= rb_wr_data;
      else             bank[rb_wr_word][7:0]  <= rb_wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [15:0] word, input logic [15:0] exp_next, input string tag);
    logic [15:0] rx;
    cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b0; din = word[15-i];
      #(HALF - 10);
      if (i == 8) chk(dout_en == 1'b1, "R1 enable in frame", {15'd0, dout_en}, 16'd1);
      rx[15-i] = dout;
      #10; sclk = 1'b1;
      #(HALF);
    end
    #(HALF); cs_n = 1'b1;
    #(2*HALF);
    got_q.push_back(rx);
    exp_q.push_back(exp_next);
    tag_q.push_back(tag);
  endtask

  task automatic abort_frame(input logic [15:0] word, input int nbits);
    cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; din = word[15-i]; #(HALF);
      sclk = 1'b1; #(HALF);
    end
    #(HALF); cs_n = 1'b1;
    #(2*HALF);
    void'(exp_q.pop_back());
    void'(tag_q.pop_back());
    exp_q.push_back(16'h0000);
    tag_q.push_back("R7 R8 after abort");
  endtask

  function automatic logic [15:0] wr_cmd(input logic [5:0] a, input logic [7:0] d);
    return {2'b10, a, d};
  endfunction
  function automatic logic [15:0] rd_cmd(input logic [5:0] a);
    return {2'b00, a, 8'hC3};
  endfunction

  initial begin : monitor
    forever begin
      @(posedge clk);
      while (got_q.size() > 0) begin
        logic [15:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g === e, t, g, e);
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    int w0;
    for (int i = 0; i < 32; i++) begin
      bank[i] = 16'hC0DE ^ (16'(i) * 16'h0907);
      mdl[i]  = bank[i];
    end
    exp_q.push_back(16'h0000);
    tag_q.push_back("R7 first frame after reset");
    #100; rst_n = 1'b1; #100;
    chk(dout_en == 1'b0, "R1 idle enable", {15'd0, dout_en}, 16'd0);

    send(rd_cmd(6'd6),  mdl[3],  "R4 even address read");
    send(rd_cmd(6'd7),  mdl[3],  "R4 odd address read");
    send(rd_cmd(6'h3F), mdl[31], "R6 polling");
    send(wr_cmd(6'd10, 8'h5A), 16'h0000, "R7 after write");
    mdl[5][7:0] = 8'h5A;
    send(wr_cmd(6'd11, 8'hA5), 16'h0000, "R7 after write");
    mdl[5][15:8] = 8'hA5;
    send(rd_cmd(6'd10), mdl[5], "R3 byte writes");
    send(rd_cmd(6'd11), mdl[5], "R2 pending read across idle wiggle");

    w0 = wr_seen;
    for (int i = 0; i < 20; i++) begin
      sclk = ~sclk; din = i[1]; #70;
      if (i == 10) chk(dout_en == 1'b0, "R1 enable idle wiggle", {15'd0, dout_en}, 16'd0);
    end
    sclk = 1'b1; #200;
    chk(wr_seen == w0, "R2 no write on idle wiggle", 16'(wr_seen), 16'(w0));

    send(rd_cmd(6'd2), mdl[1], "R6 polling");
    w0 = wr_seen;
    abort_frame(wr_cmd(6'd2, 8'hFF), 10);
    chk(wr_seen == w0, "R8 no write on abort", 16'(wr_seen), 16'(w0));
    send(rd_cmd(6'd3), mdl[1], "R8 register unchanged after abort");
    w0 = wr_seen;
    send({2'b11, 6'd2, 8'hFF}, 16'h0000, "R7 after invalid 11");
    send({2'b01, 6'd3, 8'hEE}, 16'h0000, "R7 after invalid 01");
    chk(wr_seen == w0, "R9 no write on invalid", 16'(wr_seen), 16'(w0));
    send(rd_cmd(6'd2), mdl[1], "R9 register unchanged after invalid");

    send(wr_cmd(6'd18, 8'h01), 16'h0000, "R7 after write");
    mdl[9][7:0] = 8'h01;
    send(wr_cmd(6'd19, 8'h80), 16'h0000, "R7 after write");
    mdl[9][15:8] = 8'h80;
    send(rd_cmd(6'd19), mdl[9], "R5 MSB first 8001");
    send(rd_cmd(6'd0),  mdl[0], "R6 polling");
    send(rd_cmd(6'd1),  16'h0000, "flush");
    @(posedge clk); @(posedge clk);

    for (int i = 0; i < 32; i++)
      if (bank[i] !== mdl[i]) chk(1'b0, "R3 bank contents", bank[i], mdl[i]);
    chk(1'b1, "R3 bank contents", 16'd0, 16'd0);

    finished = 1;
    #100;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule